// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic and logic stage of a simple single-cycle processor datapath. It holds two parts: a small decoder that turns a 2-bit instruction class (given by the main control) and the 6-bit function field of register-format instructions into a 4-bit operation code, and a 32-bit ALU that applies that operation to two operands. Both parts are purely combinational, so the result settles within the cycle in which the operands are presented.

Memory instructions always get an addition, so they can form an address. Compare-and-branch instructions always get a subtraction, so they can test for equality. Register-format instructions let the function field pick the operation. The ALU returns the 32-bit result and a flag that is high when that result is all zeros. The branch logic uses this flag after a subtraction.

Top module: `alu_decode_top`

## Requirements
- R1: With class input `op_class_i` = 00 (memory access), the operation is add (code 0010), whatever the function field holds.
- R2: With class input 01 (compare-and-branch), the operation is subtract (code 0110), whatever the function field holds. The zero flag is then high exactly when the operands are equal.
- R3: With class input 10 (register format), the function field selects the operation: 100000 gives add (0010), 100010 gives subtract (0110), 100100 gives AND (0000), 100101 gives OR (0001), and 101010 gives set-on-less-than (0111).
- R4: With class input 10 and function 100111, the operation is NOR (code 1100). The result is the bitwise inverse of (A OR B).
- R5: Class input 11, and class input 10 with any function value not listed in R3 or R4, both fall back to add (0010).
- R6: AND and OR give the bitwise AND and OR of A and B.
- R7: Add and subtract wrap modulo 2^32. No overflow indication is produced.
- R8: Set-on-less-than returns 1 when A is less than B as signed two's-complement values, and 0 otherwise. This holds even when A−B overflows. Result bits 31..1 are always 0.
- R9: `zero_o` is high exactly when `result_o` is all zeros.
- R10: `op_code_o` shows the 4-bit operation code chosen by the decoder, using the codes given in R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class_i | input | 2 | Instruction class from main control |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_code_o | output | 4 | Decoded ALU operation code |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when result is all zeros |

## Verification
The hardest case is set-on-less-than when the internal subtraction overflows. In that case the sign of the difference gives the wrong answer, and only operands of opposite sign at the edges of the range expose it. The stimulus drives these pairs directly through the register-format path: the most negative value against a small positive one, the most positive value against minus one, and both orders of each pair. It also drives function values that look like valid ones but are not, to confirm that they fall back to add.

// File: rtl/aludec_pkg.sv
package aludec_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_BRANCH= 2'b01,
        CLS_RFMT  = 2'b10,
        CLS_SPARE = 2'b11
    } op_class_e;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef struct packed {
        alu_op_e op;
        logic    negate_b;
        logic    is_logic;
    } dec_ctl_t;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import aludec_pkg::*;
(
    input  logic [1:0] op_class_i,
    input  logic [5:0] funct_i,
    output dec_ctl_t   ctl_o
);
    alu_op_e  fn_op_d;
    dec_ctl_t ctl_d;

    always_comb begin
        unique case (funct_i)
            FN_ADD:  fn_op_d = OP_ADD;
            FN_SUB:  fn_op_d = OP_SUB;
            FN_AND:  fn_op_d = OP_AND;
            FN_OR:   fn_op_d = OP_OR;
            FN_NOR:  fn_op_d = OP_NOR;
            FN_SLT:  fn_op_d = OP_SLT;
            default: fn_op_d = OP_ADD;
        endcase
    end

    always_comb begin
        ctl_d = '0;
        case (op_class_e'(op_class_i))
            CLS_MEM:    ctl_d.op = OP_ADD;
            CLS_BRANCH: ctl_d.op = OP_SUB;
            CLS_RFMT:   ctl_d.op = fn_op_d;
            default:    ctl_d.op = OP_ADD;
        endcase
        ctl_d.negate_b = (ctl_d.op == OP_SUB) || (ctl_d.op == OP_SLT);
        ctl_d.is_logic = (ctl_d.op == OP_AND) || (ctl_d.op == OP_OR) || (ctl_d.op == OP_NOR);
        AST_CLASS_FORCE: assert (op_class_i == 2'b10 || ctl_d.op == OP_ADD || ctl_d.op == OP_SUB); // R1
    end

    assign ctl_o = ctl_d;
endmodule

// File: rtl/alu_core.sv
module alu_core
    import aludec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dec_ctl_t           ctl_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   result_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH-1:0] sum_d;
    logic             less_d;
    logic [WIDTH-1:0] result_d;

    always_comb begin
        b_eff_d = ctl_i.negate_b ? ~b_i : b_i;
        sum_d   = a_i + b_eff_d + {{(WIDTH-1){1'b0}}, ctl_i.negate_b};
        less_d  = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : sum_d[MSB];
    end

    always_comb begin
        unique case (ctl_i.op)
            OP_AND:  result_d = a_i & b_i;
            OP_OR:   result_d = a_i | b_i;
            OP_NOR:  result_d = ~(a_i | b_i);
            OP_SLT:  result_d = {{(WIDTH-1){1'b0}}, less_d};
            default: result_d = sum_d;
        endcase
        if (ctl_i.op == OP_SLT)
            AST_SLT_NARROW: assert (result_d[WIDTH-1:1] == '0); // R8
        if (ctl_i.op == OP_AND)
            AST_AND_SUBSET: assert ((result_d & ~a_i) == '0); // R6
        if (ctl_i.op == OP_OR)
            AST_OR_COVER: assert ((result_d & a_i) == a_i); // R6
        if (ctl_i.op == OP_SUB && a_i == b_i)
            AST_SUB_SELF: assert (result_d == '0); // R7
    end

    assign result_o = result_d;
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);
    localparam int NCH    = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int PADDED = NCH * CHUNK;

    logic [PADDED-1:0] padded_d;
    logic [NCH-1:0]    any_d;

    assign padded_d = {{(PADDED-WIDTH){1'b0}}, value_i};

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        assign any_d[g] = |padded_d[g*CHUNK +: CHUNK];
    end

    assign zero_o = ~|any_d;
endmodule

// File: rtl/alu_decode_top.sv
module alu_decode_top
    import aludec_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int ZCHUNK = 8
) (
    input  logic [1:0]       op_class_i,
    input  logic [5:0]       funct_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [3:0]       op_code_o,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    dec_ctl_t         ctl_d;
    logic [WIDTH-1:0] result_d;
    logic             zero_d;

    alu_op_decoder u_dec (
        .op_class_i (op_class_i),
        .funct_i    (funct_i),
        .ctl_o      (ctl_d)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .ctl_i    (ctl_d),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (result_d)
    );

    zero_detect #(.WIDTH(WIDTH), .CHUNK(ZCHUNK)) u_zero (
        .value_i (result_d),
        .zero_o  (zero_d)
    );

    assign op_code_o = ctl_d.op;
    assign result_o  = result_d;
    assign zero_o    = zero_d;

    always_comb begin
        if (zero_d)
            AST_ZERO_MEANS_CLEAR: assert (result_d == '0); // R9
        if (op_class_i == 2'b01 && a_i == b_i)
            AST_BRANCH_EQUAL: assert (zero_d); // R2
    end
endmodule

// File: tb/tb_alu_decode_top.sv
module tb_alu_decode_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class;
    logic [5:0]  funct;
    logic [31:0] a, b;
    logic [3:0]  op_code;
    logic [31:0] result;
    logic        zero;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    alu_decode_top dut (
        .op_class_i (op_class),
        .funct_i    (funct),
        .a_i        (a),
        .b_i        (b),
        .op_code_o  (op_code),
        .result_o   (result),
        .zero_o     (zero)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        op_class = c; funct = f; a = x; b = y;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        apply(2'b00, 6'b0, 32'h0, 32'h0);
        check("R10 idle code", {28'h0, op_code}, 32'h2);
        check("R9 idle zero", {31'h0, zero}, 32'h1);
    endtask

    task automatic t_mem_class;
        apply(2'b00, 6'b100010, 32'h0000_1000, 32'hFFFF_FFFC);
        check("R1 code", {28'h0, op_code}, 32'h2);
        check("R1 sum", result, 32'h0000_0FFC);
        apply(2'b00, 6'b100100, 32'h5, 32'h7);
        check("R1 sum funct AND ignored", result, 32'hC);
    endtask

    task automatic t_branch_class;
        apply(2'b01, 6'b100000, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        check("R2 code", {28'h0, op_code}, 32'h6);
        check("R2 zero on equal", {31'h0, zero}, 32'h1);
        apply(2'b01, 6'b100101, 32'h10, 32'h11);
        check("R2 diff", result, 32'hFFFF_FFFF);
        check("R2 not zero", {31'h0, zero}, 32'h0);
    endtask

    task automatic t_rfmt_table;
        apply(2'b10, 6'b100000, 32'h7, 32'h9);
        check("R3 add code", {28'h0, op_code}, 32'h2);
        check("R3 add", result, 32'h10);
        apply(2'b10, 6'b100010, 32'h7, 32'h9);
        check("R3 sub code", {28'h0, op_code}, 32'h6);
        check("R3 sub", result, 32'hFFFF_FFFE);
        apply(2'b10, 6'b100100, 32'hF0F0_FF00, 32'hFF00_F0F0);
        check("R3 and code", {28'h0, op_code}, 32'h0);
        check("R6 and", result, 32'hF000_F000);
        apply(2'b10, 6'b100101, 32'hF0F0_FF00, 32'hFF00_F0F0);
        check("R3 or code", {28'h0, op_code}, 32'h1);
        check("R6 or", result, 32'hFFF0_FFF0);
        apply(2'b10, 6'b101010, 32'h3, 32'h4);
        check("R3 slt code", {28'h0, op_code}, 32'h7);
        check("R8 slt 3<4", result, 32'h1);
    endtask

    task automatic t_nor;
        apply(2'b10, 6'b100111, 32'hF0F0_0000, 32'h0F00_000F);
        check("R4 nor code", {28'h0, op_code}, 32'hC);
        check("R4 nor", result, 32'h000F_FFF0);
        apply(2'b10, 6'b100111, 32'hFFFF_0000, 32'h0000_FFFF);
        check("R9 nor zero", {31'h0, zero}, 32'h1);
    endtask

    task automatic t_fallback;
        apply(2'b11, 6'b100010, 32'h20, 32'h3);
        check("R5 spare class code", {28'h0, op_code}, 32'h2);
        check("R5 spare class sum", result, 32'h23);
        apply(2'b10, 6'b100110, 32'h20, 32'h3);
        check("R5 undefined funct code", {28'h0, op_code}, 32'h2);
        apply(2'b10, 6'b000010, 32'h20, 32'h3);
        check("R5 undefined funct sum", result, 32'h23);
    endtask

    task automatic t_wrap;
        apply(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h1);
        check("R7 add wrap", result, 32'h0);
        check("R9 zero after wrap", {31'h0, zero}, 32'h1);
        apply(2'b10, 6'b100010, 32'h8000_0000, 32'h1);
        check("R7 sub wrap", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_slt_overflow;
        apply(2'b10, 6'b101010, 32'h8000_0000, 32'h1);
        check("R8 min<1", result, 32'h1);
        apply(2'b10, 6'b101010, 32'h1, 32'h8000_0000);
        check("R8 1<min", result, 32'h0);
        apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check("R8 max<-1", result, 32'h0);
        apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        check("R8 -1<max", result, 32'h1);
        apply(2'b10, 6'b101010, 32'h5, 32'h5);
        check("R8 equal", result, 32'h0);
        check("R9 slt zero", {31'h0, zero}, 32'h1);
    endtask

    initial begin
        op_class = 2'b00; funct = 6'b0; a = 32'h0; b = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_mem_class();
        t_branch_class();
        t_rfmt_table();
        t_nor();
        t_fallback();
        t_wrap();
        t_slt_overflow();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule